// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller (MSI)

This block is the home node of an MSI coherence protocol that uses a directory. It serves a fixed set of caches. For every block address it keeps one directory entry, made of a protocol state, an owner node ID and a one-hot sharer vector. It also holds the backing data for those addresses. Each cycle it takes at most one request message from a cache: a read-share request, a read-modify request, a clean eviction or a dirty eviction that carries data. It answers with a single outgoing message, which is a data reply, an eviction acknowledge, an invalidate or a forwarded request. Every outgoing message names a destination node and the node that made the request.

When a block is held modified and another cache asks to share it, the controller forwards the request to the owner. The entry then waits in a transient state until the old owner's data returns on the response channel. Read requests to an entry in that transient state are held off. Responses use a channel of their own and are never blocked. The controller also drives a write port so that memory writes can be observed.

Top module: `msi_dir_ctrl`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `mem_we` are 0 and `req_ready` is 1 when no response is presented. Every entry starts in the invalid state with owner 0 and no sharers, and all block data reads as 0.
- R2: A GetS (`req_type` 0) to an invalid entry is accepted. On the next clock edge it produces a Data message (`out_type` 0) to the requester, carrying the block's stored data. The entry becomes shared, with only the requester in the sharer vector.
- R3: A GetM (`req_type` 1) to an invalid entry produces a Data message to the requester. The entry becomes modified, with the requester as owner.
- R4: A GetS to a shared entry produces a Data message to the requester and adds the requester to the sharers.
- R5: A GetM to a shared entry first produces a Data message to the requester. One Inv message (`out_type` 2) then follows per cycle, in ascending node order, to every sharer except the requester, with `out_req` set to the requester. `req_ready` stays 0 until the last Inv has been issued. The entry becomes modified, owned by the requester, with the sharers cleared.
- R6: A PutS (`req_type` 2) or PutM (`req_type` 3) to a shared entry removes the requester from the sharers and produces a Put-Ack (`out_type` 1) to the requester. If no sharer is left, the entry becomes invalid.
- R7: A GetS to a modified entry produces a FwdGetS (`out_type` 3) to the owner, with `out_req` set to the requester. The entry enters the transient state with sharers {requester, old owner} and owner 0.
- R8: A GetM to a modified entry produces a FwdGetM (`out_type` 4) to the old owner, with `out_req` set to the requester. The requester becomes the owner.
- R9: A PutM from the owner of a modified entry writes its data to the block: `mem_we` pulses with the address and data on the edge of acceptance. It then produces a Put-Ack, and the entry becomes invalid with owner 0. Any other put to a modified entry only produces a Put-Ack.
- R10: In the transient state, a GetS or GetM is not accepted (`req_ready` 0). A put removes the requester from the sharers, produces a Put-Ack and leaves the state unchanged.
- R11: A response to an entry in the transient state writes its data to the block (`mem_we` pulse) and moves the entry to shared. A response to any other entry is ignored: no write takes place and no state changes.
- R12: A put to an invalid entry produces a Put-Ack and changes neither the entry nor the data.
- R13: While `rsp_valid` is 1, `req_ready` is 0, so every response is processed in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request accepted this cycle |
| req_type | input | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| req_src | input | log2(NODES) | Requesting node |
| req_addr | input | ADDR_W | Block address |
| req_data | input | DATA_W | Data carried by PutM |
| rsp_valid | input | 1 | Data response from a former owner |
| rsp_addr | input | ADDR_W | Block address of the response |
| rsp_data | input | DATA_W | Response data |
| out_valid | output | 1 | Outgoing message valid |
| out_type | output | 3 | 0 Data, 1 Put-Ack, 2 Inv, 3 FwdGetS, 4 FwdGetM |
| out_dst | output | log2(NODES) | Destination node |
| out_req | output | log2(NODES) | Node that made the request |
| out_addr | output | ADDR_W | Block address |
| out_data | output | DATA_W | Block data for Data messages, 0 otherwise |
| mem_we | output | 1 | A block write took place on the last edge |
| mem_addr | output | ADDR_W | Address of that write |
| mem_wdata | output | DATA_W | Data of that write |

## Verification
The assertions assume that a request is either accepted or held stable by its sender, and that responses arrive only when the sender expects them. Under those assumptions, any accepted request produces exactly one message on the next edge, and an Inv burst rises in node order. The stimulus draws node, address, type and data at random over four nodes and four block addresses. Stray responses are included deliberately, to exercise the ignore path. The bench compares every output against a protocol model written from the requirements, which also covers the non-accepted cycles.

// File: rtl/msi_dir_pkg.sv
// Shared encodings for the home-node directory controller.
// Assumes: the codes below are also used by the senders and receivers of messages.
package msi_dir_pkg;
    typedef enum logic [1:0] {
        DS_I  = 2'd0,
        DS_S  = 2'd1,
        DS_M  = 2'd2,
        DS_SD = 2'd3
    } dstate_e;

    typedef enum logic [1:0] {
        RQ_GETS = 2'd0,
        RQ_GETM = 2'd1,
        RQ_PUTS = 2'd2,
        RQ_PUTM = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        MS_DATA    = 3'd0,
        MS_PUTACK  = 3'd1,
        MS_INV     = 3'd2,
        MS_FWDGETS = 3'd3,
        MS_FWDGETM = 3'd4
    } msg_e;
endpackage

// File: rtl/msi_dir_store.sv
// Directory entry array plus block data array, one slot per block address.
// Read ports are combinational. Writes occur on the clock edge.
// Assumes: ent_we and promote are never both 1 in the same cycle (the top ensures this).
module msi_dir_store
    import msi_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int ID_W  = $clog2(NODES),
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output dstate_e           rd_state,
    output logic [ID_W-1:0]   rd_owner,
    output logic [NODES-1:0]  rd_sharers,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] rsp_addr,
    output dstate_e           rsp_state,
    input  logic              ent_we,
    input  logic [ADDR_W-1:0] ent_addr,
    input  dstate_e           ent_state,
    input  logic [ID_W-1:0]   ent_owner,
    input  logic [NODES-1:0]  ent_sharers,
    input  logic              promote,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    dstate_e           st_q  [DEPTH];
    logic [ID_W-1:0]   own_q [DEPTH];
    logic [NODES-1:0]  shr_q [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Combinational lookup for the request address and the response address.
    always_comb begin
        rd_state   = st_q[rd_addr];
        rd_owner   = own_q[rd_addr];
        rd_sharers = shr_q[rd_addr];
        rd_data    = mem_q[rd_addr];
        rsp_state  = st_q[rsp_addr];
    end

    // Entry updates: a full rewrite from a request, or a promotion to shared from a response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= DS_I;
                own_q[i] <= '0;
                shr_q[i] <= '0;
            end
        end else if (ent_we) begin
            st_q[ent_addr]  <= ent_state;
            own_q[ent_addr] <= ent_owner;
            shr_q[ent_addr] <= ent_sharers;
        end else if (promote) begin
            st_q[rsp_addr] <= DS_S;
        end
    end

    // Block data writes from owner evictions and from returning responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/msi_dir_protocol.sv
// Combinational protocol decision for a single request against a single entry.
// Produces the updated entry, the reply message, the need to write memory, the set
// of sharers to invalidate, and a stall flag for reads that reach a transient entry.
// Assumes: cur_* hold the entry addressed by the request in this cycle.
module msi_dir_protocol
    import msi_dir_pkg::*;
#(
    parameter int NODES = 4,
    localparam int ID_W = $clog2(NODES)
) (
    input  dstate_e          cur_state,
    input  logic [ID_W-1:0]  cur_owner,
    input  logic [NODES-1:0] cur_sharers,
    input  req_e             rq,
    input  logic [ID_W-1:0]  src,
    output dstate_e          nxt_state,
    output logic [ID_W-1:0]  nxt_owner,
    output logic [NODES-1:0] nxt_sharers,
    output msg_e             msg_type,
    output logic [ID_W-1:0]  msg_dst,
    output logic             wr_mem,
    output logic [NODES-1:0] inv_mask,
    output logic             stall
);
    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] own_bit;
    logic [NODES-1:0] shr_less_src;
    logic             is_put;

    // One-hot forms of the requester and the owner, plus the sharers without the requester.
    always_comb begin
        src_bit      = {{(NODES-1){1'b0}}, 1'b1} << src;
        own_bit      = {{(NODES-1){1'b0}}, 1'b1} << cur_owner;
        shr_less_src = cur_sharers & ~src_bit;
        is_put       = (rq == RQ_PUTS) || (rq == RQ_PUTM);
    end

    // State-by-request decision table.
    always_comb begin
        nxt_state   = cur_state;
        nxt_owner   = cur_owner;
        nxt_sharers = cur_sharers;
        msg_type    = MS_PUTACK;
        msg_dst     = src;
        wr_mem      = 1'b0;
        inv_mask    = '0;
        stall       = 1'b0;
        unique case (cur_state)
            DS_I: begin
                if (rq == RQ_GETS) begin
                    msg_type    = MS_DATA;
                    nxt_sharers = src_bit;
                    nxt_state   = DS_S;
                end else if (rq == RQ_GETM) begin
                    msg_type  = MS_DATA;
                    nxt_owner = src;
                    nxt_state = DS_M;
                end
            end
            DS_S: begin
                if (rq == RQ_GETS) begin
                    msg_type    = MS_DATA;
                    nxt_sharers = cur_sharers | src_bit;
                end else if (rq == RQ_GETM) begin
                    msg_type    = MS_DATA;
                    inv_mask    = shr_less_src;
                    nxt_sharers = '0;
                    nxt_owner   = src;
                    nxt_state   = DS_M;
                end else begin
                    nxt_sharers = shr_less_src;
                    if (shr_less_src == '0) begin
                        nxt_state = DS_I;
                    end
                end
            end
            DS_M: begin
                if (rq == RQ_GETS) begin
                    msg_type    = MS_FWDGETS;
                    msg_dst     = cur_owner;
                    nxt_sharers = src_bit | own_bit;
                    nxt_owner   = '0;
                    nxt_state   = DS_SD;
                end else if (rq == RQ_GETM) begin
                    msg_type  = MS_FWDGETM;
                    msg_dst   = cur_owner;
                    nxt_owner = src;
                end else if (rq == RQ_PUTM && src == cur_owner) begin
                    wr_mem    = 1'b1;
                    nxt_owner = '0;
                    nxt_state = DS_I;
                end
            end
            DS_SD: begin
                if (is_put) begin
                    nxt_sharers = shr_less_src;
                end else begin
                    stall = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/msi_dir_inv_seq.sv
// Issues queued invalidates one per cycle, lowest node index first.
// Assumes: load is asserted only while busy is 0.
module msi_dir_inv_seq #(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    localparam int ID_W  = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NODES-1:0]  load_mask,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ID_W-1:0]   load_req,
    output logic              busy,
    output logic [ID_W-1:0]   inv_dst,
    output logic [ADDR_W-1:0] inv_addr,
    output logic [ID_W-1:0]   inv_req
);
    logic [NODES-1:0]  pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ID_W-1:0]   req_q;
    logic [ID_W-1:0]   low_idx;

    // Pick the lowest pending node.
    always_comb begin
        low_idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                low_idx = ID_W'(i);
            end
        end
    end

    assign busy     = |pend_q;
    assign inv_dst  = low_idx;
    assign inv_addr = addr_q;
    assign inv_req  = req_q;

    // Load a new burst, or retire the node issued this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
            req_q  <= '0;
        end else if (load) begin
            pend_q <= load_mask;
            addr_q <= load_addr;
            req_q  <= load_req;
        end else if (busy) begin
            pend_q <= pend_q & ~({{(NODES-1){1'b0}}, 1'b1} << low_idx);
        end
    end
endmodule

// File: rtl/msi_dir_ctrl.sv
// Home-node MSI directory controller top. Accepts one request per cycle when no
// response is present, no invalidate burst is draining and the request is not a read
// to a transient entry. Emits a registered message one edge after each acceptance or
// each invalidate step.
// Assumes: request senders hold a request until req_ready; responses are always taken.
module msi_dir_ctrl
    import msi_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int ID_W  = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [ID_W-1:0]   req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [ID_W-1:0]   out_dst,
    output logic [ID_W-1:0]   out_req,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    dstate_e           rd_state;
    logic [ID_W-1:0]   rd_owner;
    logic [NODES-1:0]  rd_sharers;
    logic [DATA_W-1:0] rd_data;
    dstate_e           rsp_state;
    dstate_e           nxt_state;
    logic [ID_W-1:0]   nxt_owner;
    logic [NODES-1:0]  nxt_sharers;
    msg_e              msg_type;
    logic [ID_W-1:0]   msg_dst;
    logic              p_wr_mem;
    logic [NODES-1:0]  inv_mask;
    logic              stall;
    logic              inv_busy;
    logic [ID_W-1:0]   inv_dst;
    logic [ADDR_W-1:0] inv_addr;
    logic [ID_W-1:0]   inv_req;
    logic              accept;
    logic              rsp_hit;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    msi_dir_store #(.NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(req_addr), .rd_state(rd_state), .rd_owner(rd_owner),
        .rd_sharers(rd_sharers), .rd_data(rd_data),
        .rsp_addr(rsp_addr), .rsp_state(rsp_state),
        .ent_we(accept), .ent_addr(req_addr), .ent_state(nxt_state),
        .ent_owner(nxt_owner), .ent_sharers(nxt_sharers),
        .promote(rsp_hit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    msi_dir_protocol #(.NODES(NODES)) u_proto (
        .cur_state(rd_state), .cur_owner(rd_owner), .cur_sharers(rd_sharers),
        .rq(req_e'(req_type)), .src(req_src),
        .nxt_state(nxt_state), .nxt_owner(nxt_owner), .nxt_sharers(nxt_sharers),
        .msg_type(msg_type), .msg_dst(msg_dst), .wr_mem(p_wr_mem),
        .inv_mask(inv_mask), .stall(stall)
    );

    msi_dir_inv_seq #(.NODES(NODES), .ADDR_W(ADDR_W)) u_inv (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .load_mask(inv_mask), .load_addr(req_addr), .load_req(req_src),
        .busy(inv_busy), .inv_dst(inv_dst), .inv_addr(inv_addr), .inv_req(inv_req)
    );

    // Acceptance: a response takes priority, then invalidate draining, then the stall.
    always_comb begin
        req_ready = !rsp_valid && !inv_busy && !stall;
        accept    = req_valid && req_ready;
        rsp_hit   = rsp_valid && (rsp_state == DS_SD);
    end

    // Single block-write port shared by owner evictions and responses.
    always_comb begin
        wr_en   = rsp_hit || (accept && p_wr_mem);
        wr_addr = rsp_hit ? rsp_addr : req_addr;
        wr_data = rsp_hit ? rsp_data : req_data;
    end

    // Registered outgoing message: request reply or the next invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_type  <= '0;
            out_dst   <= '0;
            out_req   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_type  <= msg_type;
            out_dst   <= msg_dst;
            out_req   <= req_src;
            out_addr  <= req_addr;
            out_data  <= (msg_type == MS_DATA) ? rd_data : '0;
        end else if (inv_busy) begin
            out_valid <= 1'b1;
            out_type  <= MS_INV;
            out_dst   <= inv_dst;
            out_req   <= inv_req;
            out_addr  <= inv_addr;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_type  <= '0;
            out_dst   <= '0;
            out_req   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end
    end

    // Registered record of the block write made on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= wr_en;
            mem_addr  <= wr_en ? wr_addr : '0;
            mem_wdata <= wr_en ? wr_data : '0;
        end
    end
endmodule

// File: rtl/msi_dir_chk.sv
// Property checker for the directory controller, attached by bind.
// Assumes: the bound signals are the top's ports and its inner entry and sequencer signals.
module msi_dir_chk #(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    localparam int ID_W  = $clog2(NODES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_type,
    input logic              rsp_valid,
    input logic [1:0]        cur_state,
    input logic              inv_busy,
    input logic              out_valid,
    input logic [2:0]        out_type,
    input logic [ID_W-1:0]   out_dst,
    input logic [ADDR_W-1:0] out_addr
);
    // R13: a presented response always blocks request acceptance.
    a_r13_rsp_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10: reads to a transient entry are never accepted.
    a_r10_stall_in_sd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_state == 2'd3 && !req_type[1]) |-> !req_ready);

    // R5: no request is taken while invalidates remain queued.
    a_r5_hold_during_inv: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |-> !req_ready);

    // R5: back-to-back invalidates rise in node order and stay on one block.
    a_r5_inv_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == 3'd2 && $past(out_valid) && $past(out_type) == 3'd2)
        |-> (out_dst > $past(out_dst) && out_addr == $past(out_addr)));

    // R2: each accepted request yields a message on the next edge.
    a_r2_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);
endmodule

bind msi_dir_ctrl msi_dir_chk #(.NODES(NODES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .rsp_valid(rsp_valid), .cur_state(rd_state),
    .inv_busy(inv_busy), .out_valid(out_valid), .out_type(out_type),
    .out_dst(out_dst), .out_addr(out_addr)
);

// File: tb/msi_dir_ctrl_bench.sv
// Bench for msi_dir_ctrl. Drives random traffic over four nodes and four blocks and
// checks every output against a protocol model written from the requirements.
module msi_dir_ctrl_bench;
    localparam int NODES = 4;
    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int IW    = 2;
    localparam int CYCLES = 6000;

    localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2, ST_SD = 2'd3;
    localparam logic [2:0] M_DATA = 3'd0, M_ACK = 3'd1, M_INV = 3'd2,
                           M_FGS = 3'd3, M_FGM = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_type = '0;
    logic [IW-1:0] req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          out_valid;
    logic [2:0]    out_type;
    logic [IW-1:0] out_dst;
    logic [IW-1:0] out_req;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int checks = 0;
    int fails  = 0;

    msi_dir_ctrl #(.NODES(NODES), .ADDR_W(AW), .DATA_W(DW)) u_msi_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_type(out_type), .out_dst(out_dst), .out_req(out_req),
        .out_addr(out_addr), .out_data(out_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #5 clk = ~clk;

    // Model state.
    logic [1:0]       m_st  [8];
    logic [IW-1:0]    m_own [8];
    logic [NODES-1:0] m_shr [8];
    logic [DW-1:0]    m_mem [8];
    logic [NODES-1:0] m_pend;
    logic [AW-1:0]    m_paddr;
    logic [IW-1:0]    m_preq;

    // Expected outputs for the next sample.
    logic          e_v;
    logic [2:0]    e_type;
    logic [IW-1:0] e_dst, e_req;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    logic          e_we;
    logic [AW-1:0] e_waddr;
    logic [DW-1:0] e_wdata;
    string         e_tag, w_tag;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        chk(e_tag, "out_valid", int'(out_valid), int'(e_v));
        if (e_v) begin
            chk(e_tag, "out_type", int'(out_type), int'(e_type));
            chk(e_tag, "out_dst", int'(out_dst), int'(e_dst));
            chk(e_tag, "out_req", int'(out_req), int'(e_req));
            chk(e_tag, "out_addr", int'(out_addr), int'(e_addr));
            chk(e_tag, "out_data", int'(out_data), int'(e_data));
        end
        chk(w_tag, "mem_we", int'(mem_we), int'(e_we));
        if (e_we) begin
            chk(w_tag, "mem_addr", int'(mem_addr), int'(e_waddr));
            chk(w_tag, "mem_wdata", int'(mem_wdata), int'(e_wdata));
        end
    endtask

    task automatic set_msg(input logic [2:0] t, input logic [IW-1:0] d, input logic [IW-1:0] r,
                           input logic [AW-1:0] a, input logic [DW-1:0] dat, input string tag);
        e_v = 1'b1; e_type = t; e_dst = d; e_req = r; e_addr = a; e_data = dat; e_tag = tag;
    endtask

    // Apply one accepted request to the model.
    task automatic model_req(input logic [1:0] t, input logic [IW-1:0] s,
                             input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [NODES-1:0] sb;
        logic [NODES-1:0] ob;
        sb = 4'b0001 << s;
        ob = 4'b0001 << m_own[a];
        case (m_st[a])
            ST_I: begin
                if (t == 2'd0) begin
                    set_msg(M_DATA, s, s, a, m_mem[a], "R2");
                    m_shr[a] = sb; m_st[a] = ST_S;
                end else if (t == 2'd1) begin
                    set_msg(M_DATA, s, s, a, m_mem[a], "R3");
                    m_own[a] = s; m_st[a] = ST_M;
                end else begin
                    set_msg(M_ACK, s, s, a, '0, "R12");
                end
            end
            ST_S: begin
                if (t == 2'd0) begin
                    set_msg(M_DATA, s, s, a, m_mem[a], "R4");
                    m_shr[a] = m_shr[a] | sb;
                end else if (t == 2'd1) begin
                    set_msg(M_DATA, s, s, a, m_mem[a], "R5");
                    m_pend = m_shr[a] & ~sb; m_paddr = a; m_preq = s;
                    m_shr[a] = '0; m_own[a] = s; m_st[a] = ST_M;
                end else begin
                    set_msg(M_ACK, s, s, a, '0, "R6");
                    m_shr[a] = m_shr[a] & ~sb;
                    if (m_shr[a] == '0) m_st[a] = ST_I;
                end
            end
            ST_M: begin
                if (t == 2'd0) begin
                    set_msg(M_FGS, m_own[a], s, a, '0, "R7");
                    m_shr[a] = sb | ob; m_own[a] = '0; m_st[a] = ST_SD;
                end else if (t == 2'd1) begin
                    set_msg(M_FGM, m_own[a], s, a, '0, "R8");
                    m_own[a] = s;
                end else if (t == 2'd3 && s == m_own[a]) begin
                    set_msg(M_ACK, s, s, a, '0, "R9");
                    e_we = 1'b1; e_waddr = a; e_wdata = d; w_tag = "R9";
                    m_mem[a] = d; m_own[a] = '0; m_st[a] = ST_I;
                end else begin
                    set_msg(M_ACK, s, s, a, '0, "R9");
                end
            end
            default: begin
                set_msg(M_ACK, s, s, a, '0, "R10");
                m_shr[a] = m_shr[a] & ~sb;
            end
        endcase
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic          rv, qv, exp_ready;
        logic [1:0]    qt;
        logic [IW-1:0] qs;
        logic [AW-1:0] qa, ra;
        logic [DW-1:0] qd, rd;
        string         rtag;

        for (int i = 0; i < 8; i++) begin
            m_st[i] = ST_I; m_own[i] = '0; m_shr[i] = '0; m_mem[i] = '0;
        end
        m_pend = '0; m_paddr = '0; m_preq = '0;

        // R1: idle outputs during reset.
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "mem_we in reset", int'(mem_we), 0);
        chk("R1", "req_ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        e_v = 1'b0; e_we = 1'b0; e_tag = "R1"; w_tag = "R1";
        e_type = '0; e_dst = '0; e_req = '0; e_addr = '0; e_data = '0;
        e_waddr = '0; e_wdata = '0;

        for (int c = 0; c < CYCLES; c++) begin
            @(negedge clk);
            compare_outputs();

            rv = ($urandom % 8) == 0;
            ra = AW'($urandom % 4);
            rd = DW'($urandom);
            qv = ($urandom % 4) != 0;
            qt = 2'($urandom);
            qs = IW'($urandom);
            qa = AW'($urandom % 4);
            qd = DW'($urandom);
            rsp_valid = rv; rsp_addr = ra; rsp_data = rd;
            req_valid = qv; req_type = qt; req_src = qs; req_addr = qa; req_data = qd;
            #1;

            exp_ready = !rv && (m_pend == '0) && !(!qt[1] && m_st[qa] == ST_SD);
            if (rv) rtag = "R13";
            else if (m_pend != '0) rtag = "R5";
            else if (!qt[1] && m_st[qa] == ST_SD) rtag = "R10";
            else rtag = "R2";
            chk(rtag, "req_ready", int'(req_ready), int'(exp_ready));

            e_v = 1'b0; e_we = 1'b0; e_tag = "R2"; w_tag = "R11";
            if (rv && m_st[ra] == ST_SD) begin
                e_we = 1'b1; e_waddr = ra; e_wdata = rd; w_tag = "R11";
                m_mem[ra] = rd; m_st[ra] = ST_S;
            end
            if (m_pend != '0) begin
                for (int n = NODES - 1; n >= 0; n--) begin
                    if (m_pend[n]) e_dst = IW'(n);
                end
                set_msg(M_INV, e_dst, m_preq, m_paddr, '0, "R5");
                m_pend[e_dst] = 1'b0;
            end else if (qv && exp_ready) begin
                model_req(qt, qs, qa, qd);
            end
        end

        @(negedge clk);
        compare_outputs();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule